// File: doc/BRIEF.md
# Single-Wire Bus Frame Receiver

This block listens to an idle-high, single-wire bus shared by several nodes and recovers the bytes that another node sends. It never drives the line. A sender claims the bus by pulling the line low for a long time. The receiver accepts that as a frame start only once the low has lasted a minimum number of cycles. Shorter lows are dropped, such as the brief low-high-low pulse a sender uses to check the line, and so is a low that is cut short by a high.

After a valid start, data arrives as return-to-zero bits. Each bit begins with a rising edge, and the line level a fixed number of cycles later gives the bit value. The line then returns low before the next bit. Bits are packed MSB first into bytes, and each byte is presented on a valid/ready output.

A high that lasts the idle period closes the frame, and a one-cycle end pulse reports it. An error flag accompanies that pulse when the frame left an incomplete byte or lost a byte to back-pressure. All thresholds are parameters in clock cycles, and the asynchronous bus input passes through a two-stage synchroniser.

Top module: `swb_rx`

## Requirements
- R1: After reset, `m_valid`, `frame_end` and `frame_err` are 0, and a line held high produces no output.
- R2: A frame starts only when the synchronised line stays low for at least `START_MIN` consecutive cycles. Any shorter low, including a short low-high-low check pulse, produces no byte and no `frame_end`.
- R3: If the line goes high while a candidate start is still too short, the receiver returns to idle. A following long high then produces no output.
- R4: Within a frame, each rising edge begins a bit, and the bit value is the line level `SAMPLE_DLY` cycles after the first high cycle (high = 1, low = 0). A high pulse of `SAMPLE_DLY+1` to `IDLE_END-1` cycles therefore decodes as 1. A high pulse of `SAMPLE_DLY` cycles or fewer decodes as 0.
- R5: Bits fill a byte MSB first. The first bit of a frame lands in `m_data[7]`, and each eighth bit completes a byte that is offered on `m_data`/`m_valid`.
- R6: A high lasting `IDLE_END` consecutive cycles ends the frame with a single-cycle `frame_end` pulse. The rising edge that starts this final high contributes no bit.
- R7: If the frame ends with 1 to 7 bits of an unfinished byte, those bits are discarded and `frame_err` is 1 during the `frame_end` pulse. The next frame starts with an empty byte.
- R8: Back-pressure follows these rules. Once `m_valid` is 1, it and `m_data` hold until a cycle with `m_ready` = 1. A byte that completes while the previous one is still held is dropped, and `frame_err` is then raised with that frame's `frame_end`.
- R9: `frame_err` is never 1 outside a `frame_end` pulse.
- R10: `frame_end` never stays high for two consecutive cycles, and never coincides with a newly raised `m_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| bus_in | input | 1 | Raw bus line, idle high, asynchronous to `clk` |
| m_data | output | 8 | Received byte, MSB is the earliest bit |
| m_valid | output | 1 | `m_data` holds a byte not yet taken |
| m_ready | input | 1 | Downstream accepts the byte in this cycle |
| frame_end | output | 1 | One-cycle pulse when a frame closes |
| frame_err | output | 1 | With `frame_end`: a partial byte was discarded or a byte was dropped |

## Verification
The bench builds the receiver with `START_MIN` = 8, `IDLE_END` = 12 and `SAMPLE_DLY` = 2. With these values every threshold sits a few cycles from its neighbour, so a short test can drive each boundary directly. A 7-cycle low is rejected while an 8-cycle low starts a frame. High pulses of 2 and 3 cycles decode as 0 and 1. An 11-cycle high is still a 1 bit, while a 12-cycle high ends the frame. Because frames are short, the bench can also hold `m_ready` low across two bytes to force a dropped byte.

// File: rtl/swb_rx_pkg.sv
package swb_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // line high, no frame
    ST_CAND,   // low seen, timing candidate start
    ST_LOW,    // inside frame, waiting for a rising edge
    ST_BITHI,  // rising edge seen, waiting for sample point
    ST_HOLD    // sampled high, waiting for fall or idle timeout
  } swb_state_e;
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/swb_line_fsm.sv
module swb_line_fsm
  import swb_rx_pkg::*;
#(
  parameter int START_MIN  = 16,
  parameter int IDLE_END   = 40,
  parameter int SAMPLE_DLY = 2,
  parameter int CW         = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic bit_stb,
  output logic bit_val,
  output logic frm_start,
  output logic frm_end
);
  localparam logic [CW-1:0] START_LAST = CW'(START_MIN - 1);
  localparam logic [CW-1:0] IDLE_LAST  = CW'(IDLE_END - 1);
  localparam logic [CW-1:0] SAMP_AT    = CW'(SAMPLE_DLY);

  swb_state_e     state;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bit_stb   <= 1'b0;
      bit_val   <= 1'b0;
      frm_start <= 1'b0;
      frm_end   <= 1'b0;
    end else begin
      bit_stb   <= 1'b0;
      frm_start <= 1'b0;
      frm_end   <= 1'b0;
      case (state)
        ST_IDLE: if (!line) begin
          state <= ST_CAND;
          cnt   <= CW'(1);
        end
        ST_CAND: begin
          if (line) state <= ST_IDLE;
          else if (cnt >= START_LAST) begin
            state     <= ST_LOW;
            frm_start <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_LOW: if (line) begin
          state <= ST_BITHI;
          cnt   <= CW'(1);
        end
        ST_BITHI: begin
          if (cnt >= SAMP_AT) begin
            if (line) begin
              state <= ST_HOLD;
              cnt   <= cnt + 1'b1;
            end else begin
              bit_stb <= 1'b1;
              bit_val <= 1'b0;
              state   <= ST_LOW;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_HOLD: begin
          if (!line) begin
            bit_stb <= 1'b1;
            bit_val <= 1'b1;
            state   <= ST_LOW;
          end else if (cnt >= IDLE_LAST) begin
            frm_end <= 1'b1;
            state   <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swb_byte_asm.sv
module swb_byte_asm #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  output logic              frame_end,
  output logic              frame_err
);
  localparam int BCW = $clog2(DATA_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [BCW-1:0]    nb;
  logic              ovr;
  logic [DATA_W-1:0] sh_nx;
  logic              full;
  logic              slot_free;

  assign sh_nx     = {sh[DATA_W-2:0], bit_val};
  assign full      = bit_stb && (nb == LAST_BIT);
  assign slot_free = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      nb        <= '0;
      ovr       <= 1'b0;
      m_data    <= '0;
      m_valid   <= 1'b0;
      frame_end <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      frame_end <= frm_end;
      frame_err <= frm_end && ((nb != '0) || ovr);
      if (frm_start || frm_end) begin
        nb  <= '0;
        ovr <= 1'b0;
      end else if (bit_stb) begin
        sh <= sh_nx;
        nb <= full ? '0 : nb + 1'b1;
        if (full && !slot_free) ovr <= 1'b1;
      end
      if (full && slot_free) begin
        m_valid <= 1'b1;
        m_data  <= sh_nx;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swb_rx.sv
module swb_rx #(
  parameter int START_MIN   = 16,
  parameter int IDLE_END    = 40,
  parameter int SAMPLE_DLY  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_in,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              frame_end,
  output logic              frame_err
);
  localparam int MAXT = (START_MIN > IDLE_END) ? START_MIN : IDLE_END;
  localparam int CW   = $clog2(MAXT + 1) + 1;

  logic line_s;
  logic bit_stb, bit_val, frm_start, frm_end;

  swb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line_s)
  );

  swb_line_fsm #(
    .START_MIN(START_MIN), .IDLE_END(IDLE_END),
    .SAMPLE_DLY(SAMPLE_DLY), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .line(line_s),
    .bit_stb(bit_stb), .bit_val(bit_val),
    .frm_start(frm_start), .frm_end(frm_end)
  );

  swb_byte_asm #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb), .bit_val(bit_val),
    .frm_start(frm_start), .frm_end(frm_end),
    .m_ready(m_ready), .m_data(m_data), .m_valid(m_valid),
    .frame_end(frame_end), .frame_err(frame_err)
  );
endmodule

// File: rtl/swb_rx_chk.sv
module swb_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] m_data,
  input logic              m_valid,
  input logic              m_ready,
  input logic              frame_end,
  input logic              frame_err
);
  a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid);

  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> $stable(m_data));

  a_r9_err_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> frame_end);

  a_r10_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  a_r10_end_not_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !$rose(m_valid));
endmodule

bind swb_rx swb_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_data(m_data), .m_valid(m_valid),
  .m_ready(m_ready), .frame_end(frame_end), .frame_err(frame_err)
);

// File: tb/tb_swb_rx.sv
`timescale 1ns/100ps
module tb_swb_rx;
  localparam int START_MIN = 8;
  localparam int IDLE_END  = 12;
  localparam int SAMP      = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_in = 1'b1;
  logic       m_ready = 1'b1;
  logic [7:0] m_data;
  logic       m_valid, frame_end, frame_err;

  int n_chk = 0;
  int n_fail = 0;
  int rx_buf [64];
  int rx_n = 0;
  int n_end = 0;
  int last_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  swb_rx #(.START_MIN(START_MIN), .IDLE_END(IDLE_END), .SAMPLE_DLY(SAMP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
    .frame_end(frame_end), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready && rx_n < 64) begin
      rx_buf[rx_n] = int'(m_data);
      rx_n = rx_n + 1;
    end
    if (rst_n && frame_end) begin
      n_end = n_end + 1;
      last_err = int'(frame_err);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic hold(input bit v, input int n);
    bus_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    rx_n = 0;
    n_end = 0;
    last_err = 0;
  endtask

  task automatic send_bit(input bit b);
    hold(1'b1, b ? 6 : 1);
    hold(1'b0, 3);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic release_bus();
    hold(1'b1, 20);
  endtask

  task automatic t_reset();
    chk(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);
    chk(frame_end == 1'b0, "R1 frame_end after reset", int'(frame_end), 0);
    chk(frame_err == 1'b0, "R1 frame_err after reset", int'(frame_err), 0);
    clear_log();
    hold(1'b1, 30);
    chk(rx_n == 0 && n_end == 0, "R1 idle high silent", rx_n + n_end, 0);
  endtask

  task automatic t_bytes();
    clear_log();
    hold(1'b0, 10);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF); send_byte(8'h00);
    release_bus();
    chk(rx_n == 4, "R5 byte count", rx_n, 4);
    chk(rx_buf[0] == 'hA5, "R5 byte0 MSB first", rx_buf[0], 'hA5);
    chk(rx_buf[1] == 'h3C, "R4 byte1", rx_buf[1], 'h3C);
    chk(rx_buf[2] == 'hFF, "R4 byte2 all ones", rx_buf[2], 'hFF);
    chk(rx_buf[3] == 'h00, "R4 byte3 all zeros", rx_buf[3], 'h00);
    chk(n_end == 1, "R6 one frame_end", n_end, 1);
    chk(last_err == 0, "R7 clean frame no error", last_err, 0);
  endtask

  task automatic t_short_lows();
    clear_log();
    hold(1'b0, START_MIN - 1); hold(1'b1, 4);
    hold(1'b0, 3); hold(1'b1, 2); hold(1'b0, 2);
    hold(1'b1, 30);
    chk(rx_n == 0, "R2 short lows give no byte", rx_n, 0);
    chk(n_end == 0, "R3 false alarm gives no frame_end", n_end, 0);
  endtask

  task automatic t_check_pulse_then_frame();
    clear_log();
    hold(1'b0, 3); hold(1'b1, 2);
    hold(1'b0, START_MIN);
    send_byte(8'h81);
    release_bus();
    chk(rx_n == 1 && rx_buf[0] == 'h81, "R2 min low after check pulse", rx_buf[0], 'h81);
    chk(n_end == 1, "R6 end after check-pulse frame", n_end, 1);
  endtask

  task automatic t_sample_point();
    int w [8] = '{3, 2, IDLE_END - 1, 2, 3, 3, 1, IDLE_END - 1};
    clear_log();
    hold(1'b0, 10);
    for (int i = 0; i < 8; i++) begin
      hold(1'b1, w[i]);
      hold(1'b0, 3);
    end
    release_bus();
    chk(rx_n == 1 && rx_buf[0] == 'hAD, "R4 sample point widths", rx_buf[0], 'hAD);
    chk(n_end == 1, "R6 11-cycle high is a bit not an end", n_end, 1);
  endtask

  task automatic t_partial();
    clear_log();
    hold(1'b0, 10);
    send_byte(8'h5A);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    release_bus();
    chk(rx_n == 1 && rx_buf[0] == 'h5A, "R7 full byte kept", rx_buf[0], 'h5A);
    chk(last_err == 1, "R7 partial byte flags error", last_err, 1);
    clear_log();
    hold(1'b0, 10);
    send_byte(8'hC3);
    release_bus();
    chk(rx_n == 1 && rx_buf[0] == 'hC3, "R7 next frame starts empty", rx_buf[0], 'hC3);
    chk(last_err == 0, "R7 next frame clean", last_err, 0);
  endtask

  task automatic t_backpressure();
    clear_log();
    m_ready = 1'b0;
    hold(1'b0, 10);
    send_byte(8'h11); send_byte(8'h22);
    release_bus();
    chk(m_valid == 1'b1, "R8 valid held", int'(m_valid), 1);
    chk(m_data == 8'h11, "R8 first byte held", int'(m_data), 'h11);
    chk(last_err == 1, "R8 dropped byte flags error", last_err, 1);
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_n == 1 && rx_buf[0] == 'h11, "R8 only held byte delivered", rx_n, 1);
    chk(m_valid == 1'b0, "R8 valid clears after accept", int'(m_valid), 0);
  endtask

  task automatic t_empty_frame();
    clear_log();
    hold(1'b0, 10);
    release_bus();
    chk(n_end == 1, "R10 single end pulse", n_end, 1);
    chk(rx_n == 0, "R6 release edge adds no bit", rx_n, 0);
    chk(last_err == 0, "R6 empty frame no error", last_err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_short_lows();
    t_check_pulse_then_frame();
    t_sample_point();
    t_partial();
    t_backpressure();
    t_empty_frame();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule